// File: doc/BRIEF.md
# Indirect Bucket Configuration Access Engine

This block gives a host indirect access to a bucket configuration store. The store is organised by port, by resource (bucket) within a port, and by one of eight 16-bit registers within a resource. The host sees two registers: a 16-bit data register and a 16-bit command word. To write, the host loads the data register and then writes a command word with the start bit set. To read, the host writes a read command, waits for busy to drop, and then takes the result from the data register.

The engine also runs two maintenance commands. The first clears the whole store, one entry per clock, and restores the global tick-interval setting to its default. The second opens a short clear window that the metering datapath uses to reset the running state of one bucket. A separate global register, reached through a reserved port address, drives the tick-interval output that paces the meters.

Only one command runs at a time. While busy is high, the engine ignores every host write, whether to the command word or to the data register. A malformed command is discarded in a single cycle and leaves all state unchanged.

Top module: `bcfg_access_engine`

## Requirements
- R1: After reset, busy is 0, the data register reads 0x0000, tick_interval is 4, and every store location holds 0x0000.
- R2: The command word is laid out as follows: bit 15 start, bits 14:12 opcode, bits 11:8 port, bits 7:5 resource, bit 4 unused, bits 3:0 register index. The opcodes are 1 = clear whole store, 2 = clear one bucket, 3 = write, 4 = read. A command word written with bit 15 clear is ignored.
- R3: A write command stores the data register into the addressed location. Busy is high for exactly one cycle after the command is accepted.
- R4: A read command loads the addressed location into the data register. The value is there when busy drops, and busy is high for exactly one cycle.
- R5: Port 15, resource 0, register 1 addresses the global register. It can be written and read through the normal commands, and its bits 2:0 drive tick_interval.
- R6: A clear-whole-store command writes zero to every location, one per cycle. Busy stays high for NUM_PORTS*NUM_RES*8+1 cycles, and when the command finishes the global register holds 4.
- R7: A clear-one-bucket command drives bucket_clr high for CLR_CYCLES cycles, with the addressed port and resource on bucket_clr_port and bucket_clr_res. Busy is high for CLR_CYCLES+1 cycles, and the store is not changed.
- R8: While busy is high, host writes to the command word and to the data register have no effect.
- R9: The following commands finish with busy high for one cycle and change neither the store nor the data register: an unused opcode (0, 5, 6, 7); a port at or above NUM_PORTS other than the global address; a resource at or above NUM_RES; a register index above 7. A clear-one-bucket command with an out-of-range address does not raise bucket_clr.
- R10: Every valid (port, resource, register) triple selects its own location. A write to one triple does not change any other triple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Target of the host write: 0 = data register, 1 = command word |
| host_wdata | input | 16 | Host write value |
| data_q | output | 16 | Data register contents |
| busy | output | 1 | Command in progress |
| tick_interval | output | 3 | Meter tick-interval setting from the global register |
| bucket_clr | output | 1 | Clear strobe for the running state of one bucket |
| bucket_clr_port | output | 4 | Port of the bucket being cleared |
| bucket_clr_res | output | 3 | Resource of the bucket being cleared |

## Verification
The bench writes to addresses that would alias if the flat index were formed wrongly, such as resource 5 of port 0 and register index 9. A design that only truncates the index, and does not reject the command, would corrupt a neighbouring bucket. The bench also writes the data register and the command word in the middle of a store-wide clear; a design that accepts either write would leave a non-zero word behind or a changed data register. Busy lengths are counted exactly for every opcode, so an off-by-one in the sweep or in the clear window shows up as a wrong count. The tick interval is changed and then checked to return to 4 after the sweep.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int REGS_PER_RES = 8;
    localparam logic [3:0] GLB_PORT = 4'hF;
    localparam logic [2:0] GLB_RES = 3'd0;
    localparam logic [3:0] GLB_IDX = 4'd1;
    localparam logic [15:0] GLB_DEFAULT = 16'h0004;

    localparam logic [2:0] OP_CLEAR_ALL = 3'd1;
    localparam logic [2:0] OP_CLEAR_ONE = 3'd2;
    localparam logic [2:0] OP_WRITE = 3'd3;
    localparam logic [2:0] OP_READ = 3'd4;

    typedef struct packed {
        logic       start;
        logic [2:0] op;
        logic [3:0] port;
        logic [2:0] res;
        logic       pad;
        logic [3:0] idx;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_SWEEP,
        ST_CLR
    } state_e;

    typedef enum logic [2:0] {
        K_BAD,
        K_WRITE_MEM,
        K_READ_MEM,
        K_WRITE_GLB,
        K_READ_GLB,
        K_CLEAR_ALL,
        K_CLEAR_ONE
    } kind_e;

    function automatic int flat_index(input logic [3:0] port, input logic [2:0] res,
                                      input logic [3:0] idx, input int nres);
        return (int'(port) * nres + int'(res)) * REGS_PER_RES + int'(idx);
    endfunction

endpackage

// File: rtl/bcfg_decode.sv
module bcfg_decode
    import bcfg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_RES   = 5,
    parameter int AW        = 8
) (
    input  cmd_t            cmd,
    output kind_e           kind,
    output logic [AW-1:0]   addr
);

    logic port_ok, res_ok, idx_ok, is_glb, in_range;
    logic unused_pad;

    assign unused_pad = cmd.pad;
    assign port_ok  = int'(cmd.port) < NUM_PORTS;
    assign res_ok   = int'(cmd.res) < NUM_RES;
    assign idx_ok   = int'(cmd.idx) < REGS_PER_RES;
    assign is_glb   = (cmd.port == GLB_PORT) && (cmd.res == GLB_RES) && (cmd.idx == GLB_IDX);
    assign in_range = port_ok && res_ok && idx_ok;
    assign addr     = AW'(flat_index(cmd.port, cmd.res, cmd.idx, NUM_RES));

    always_comb begin
        kind = K_BAD;
        case (cmd.op)
            OP_CLEAR_ALL: kind = K_CLEAR_ALL;
            OP_CLEAR_ONE: kind = (port_ok && res_ok) ? K_CLEAR_ONE : K_BAD;
            OP_WRITE:     kind = is_glb ? K_WRITE_GLB : (in_range ? K_WRITE_MEM : K_BAD);
            OP_READ:      kind = is_glb ? K_READ_GLB  : (in_range ? K_READ_MEM  : K_BAD);
            default:      kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/bcfg_store.sv
module bcfg_store #(
    parameter int DEPTH = 160,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R10: only addresses inside the store are ever written
    p_waddr_range_r10: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/bcfg_access_engine.sv
module bcfg_access_engine
    import bcfg_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int NUM_RES    = 5,
    parameter int CLR_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] data_q,
    output logic        busy,
    output logic [2:0]  tick_interval,
    output logic        bucket_clr,
    output logic [3:0]  bucket_clr_port,
    output logic [2:0]  bucket_clr_res
);

    localparam int DEPTH = NUM_PORTS * NUM_RES * REGS_PER_RES;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(CLR_CYCLES) + 1;

    state_e          state_q;
    cmd_t            cmd_q;
    logic [15:0]     data_r;
    logic [15:0]     glb_r;
    logic [AW-1:0]   sweep_idx;
    logic [CW-1:0]   clr_cnt;
    kind_e           kind;
    logic [AW-1:0]   dec_addr;
    logic            accept;
    logic            sweep_last;
    logic            mem_we;
    logic [AW-1:0]   mem_waddr;
    logic [15:0]     mem_wdata;
    logic [15:0]     mem_rdata;

    bcfg_decode #(.NUM_PORTS(NUM_PORTS), .NUM_RES(NUM_RES), .AW(AW)) u_decode (
        .cmd  (cmd_q),
        .kind (kind),
        .addr (dec_addr)
    );

    bcfg_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (dec_addr),
        .rdata (mem_rdata)
    );

    assign busy       = (state_q != ST_IDLE);
    assign accept     = host_wr && host_sel && host_wdata[15] && !busy;
    assign sweep_last = (sweep_idx == AW'(DEPTH - 1));

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = dec_addr;
        mem_wdata = data_r;
        if (state_q == ST_SWEEP) begin
            mem_we    = 1'b1;
            mem_waddr = sweep_idx;
            mem_wdata = '0;
        end else if (state_q == ST_EXEC && kind == K_WRITE_MEM) begin
            mem_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cmd_q     <= '0;
            data_r    <= '0;
            glb_r     <= GLB_DEFAULT;
            sweep_idx <= '0;
            clr_cnt   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (host_wr && !host_sel) data_r <= host_wdata;
                    if (accept) begin
                        cmd_q   <= cmd_t'(host_wdata);
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    state_q <= ST_IDLE;
                    case (kind)
                        K_READ_MEM:  data_r <= mem_rdata;
                        K_READ_GLB:  data_r <= glb_r;
                        K_WRITE_GLB: glb_r  <= data_r;
                        K_CLEAR_ALL: begin
                            sweep_idx <= '0;
                            state_q   <= ST_SWEEP;
                        end
                        K_CLEAR_ONE: begin
                            clr_cnt <= '0;
                            state_q <= ST_CLR;
                        end
                        default: ;
                    endcase
                end
                ST_SWEEP: begin
                    sweep_idx <= sweep_idx + 1'b1;
                    if (sweep_last) begin
                        glb_r   <= GLB_DEFAULT;
                        state_q <= ST_IDLE;
                    end
                end
                ST_CLR: begin
                    clr_cnt <= clr_cnt + 1'b1;
                    if (clr_cnt == CW'(CLR_CYCLES - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign data_q          = data_r;
    assign tick_interval   = glb_r[2:0];
    assign bucket_clr      = (state_q == ST_CLR);
    assign bucket_clr_port = cmd_q.port;
    assign bucket_clr_res  = cmd_q.res;

    // R8: a command word written during a busy period is dropped
    p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr && host_sel) |=> $stable(cmd_q));

    // R8: the data register only moves on a read result while busy
    p_data_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !(state_q == ST_EXEC && (kind == K_READ_MEM || kind == K_READ_GLB)))
        |=> $stable(data_q));

    // R9: a rejected command ends in one cycle
    p_bad_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && kind == K_BAD) |=> !busy);

    // R9: a rejected command never touches the store
    p_bad_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && kind == K_BAD) |-> !mem_we);

    // R6: the sweep leaves the default tick interval behind
    p_interval_after_sweep_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWEEP && sweep_last) |=> (tick_interval == 3'd4));

    // R7: the clear window closes together with busy
    p_clr_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(bucket_clr) |-> !busy);

endmodule

// File: tb/bcfg_access_engine_bench.sv
`timescale 1ns/1ps
module bcfg_access_engine_bench;

    localparam int NUM_PORTS  = 4;
    localparam int NUM_RES    = 5;
    localparam int CLR_CYCLES = 4;
    localparam int DEPTH      = NUM_PORTS * NUM_RES * 8;

    // {command word, data preload, expected read value}
    localparam int NV = 13;
    localparam logic [47:0] VEC [NV] = '{
        48'hB000_1234_0000,
        48'hB007_A5A5_0000,
        48'hB100_0F0F_0000,
        48'hB387_BEEF_0000,
        48'hB243_5555_0000,
        48'hB021_7777_0000,
        48'hC000_FFFF_1234,
        48'hC007_FFFF_A5A5,
        48'hC100_FFFF_0F0F,
        48'hC387_FFFF_BEEF,
        48'hC243_FFFF_5555,
        48'hC021_FFFF_7777,
        48'hC200_FFFF_0000
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr;
    logic        host_sel;
    logic [15:0] host_wdata;
    logic [15:0] data_q;
    logic        busy;
    logic [2:0]  tick_interval;
    logic        bucket_clr;
    logic [3:0]  bucket_clr_port;
    logic [2:0]  bucket_clr_res;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [3:0] seen_port;
    logic [2:0] seen_res;

    always #4 clk = ~clk;

    bcfg_access_engine #(.NUM_PORTS(NUM_PORTS), .NUM_RES(NUM_RES), .CLR_CYCLES(CLR_CYCLES))
    u_bcfg_access_engine (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .data_q(data_q), .busy(busy),
        .tick_interval(tick_interval), .bucket_clr(bucket_clr),
        .bucket_clr_port(bucket_clr_port), .bucket_clr_res(bucket_clr_res)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle(output int bcnt, output int ccnt);
        int guard = 0;
        bcnt = 0; ccnt = 0;
        while (busy && guard < 1000) begin
            bcnt++;
            if (bucket_clr) begin
                ccnt++;
                seen_port = bucket_clr_port;
                seen_res  = bucket_clr_res;
            end
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic do_cmd(input logic [15:0] data, input logic [15:0] cmd,
                          output int bcnt, output int ccnt);
        host_write(1'b0, data);
        host_write(1'b1, cmd);
        wait_idle(bcnt, ccnt);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int b, c;
        logic [47:0] v;
        rst = 1'b1; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 data register", data_q, 16'h0000);
        check("R1 tick interval", tick_interval, 3'd4);
        do_cmd(16'hFFFF, 16'hC387, b, c);
        check("R1 store cleared", data_q, 16'h0000);

        // R3 R4 R10: table of writes and read-backs
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            do_cmd(v[31:16], v[47:32], b, c);
            check("R3 R4 busy length", b, 1);
            if (v[46:44] == 3'd4) check("R4 R10 read value", data_q, v[15:0]);
        end

        // R5: global register
        do_cmd(16'hFFFF, 16'hCF01, b, c);
        check("R5 global read default", data_q, 16'h0004);
        do_cmd(16'h0007, 16'hBF01, b, c);
        check("R5 interval written", tick_interval, 3'd7);
        do_cmd(16'h0000, 16'hCF01, b, c);
        check("R5 global read back", data_q, 16'h0007);

        // R2: start bit clear is ignored
        do_cmd(16'h9999, 16'h3000, b, c);
        check("R2 no start no busy", b, 0);
        do_cmd(16'hFFFF, 16'hC000, b, c);
        check("R2 store unchanged", data_q, 16'h1234);

        // R9: malformed commands
        do_cmd(16'h4242, 16'hB0A0, b, c);
        check("R9 bad resource busy", b, 1);
        do_cmd(16'hFFFF, 16'hC100, b, c);
        check("R9 no alias resource", data_q, 16'h0F0F);
        do_cmd(16'h4242, 16'hB009, b, c);
        check("R9 bad index busy", b, 1);
        do_cmd(16'hFFFF, 16'hC021, b, c);
        check("R9 no alias index", data_q, 16'h7777);
        do_cmd(16'h4242, 16'hB400, b, c);
        check("R9 bad port busy", b, 1);
        do_cmd(16'h4242, 16'hD000, b, c);
        check("R9 unused opcode busy", b, 1);
        do_cmd(16'h1357, 16'hC0A0, b, c);
        check("R9 bad read keeps data", data_q, 16'h1357);
        do_cmd(16'h0000, 16'hA0A0, b, c);
        check("R9 bad clear no strobe", c, 0);

        // R7: clear one bucket
        do_cmd(16'h0000, 16'hA260, b, c);
        check("R7 busy length", b, CLR_CYCLES + 1);
        check("R7 strobe length", c, CLR_CYCLES);
        check("R7 strobe port", seen_port, 4'd2);
        check("R7 strobe resource", seen_res, 3'd3);
        do_cmd(16'hFFFF, 16'hC243, b, c);
        check("R7 store untouched", data_q, 16'h5555);

        // R6: clear whole store
        do_cmd(16'h0000, 16'h9000, b, c);
        check("R6 busy length", b, DEPTH + 1);
        check("R6 interval restored", tick_interval, 3'd4);
        do_cmd(16'hFFFF, 16'hC387, b, c);
        check("R6 location zeroed", data_q, 16'h0000);

        // R8: host writes during a sweep are dropped
        host_write(1'b0, 16'h1111);
        host_write(1'b1, 16'h9000);
        host_write(1'b0, 16'hDEAD);
        host_write(1'b1, 16'hB000);
        wait_idle(b, c);
        check("R8 data register held", data_q, 16'h1111);
        @(negedge clk);
        check("R8 no late command", busy, 0);
        do_cmd(16'hFFFF, 16'hC000, b, c);
        check("R8 write dropped", data_q, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule